// File: doc/BRIEF.md
# Asynchronous Bus Cycle Master Sequencer

This block runs one read or one write transfer for a processor-style bus master on an asynchronous, non-multiplexed 32-bit data bus. A request brings an address, write data, a direction flag and an operand size of one to four bytes. The block then drives the address strobe, the data strobe, the data buffer enable and the output enable of the data drivers. Each edge falls on a rising or a falling clock phase, and the timing is different for reads and for writes.

A slave ends the cycle with a two-wire, active-low acknowledge. The code on those wires also reports the width of the responding port. The acknowledge wires pass through a synchronizer first. While the slave leaves both wires high, the cycle stretches by whole clocks. When the cycle ends, the block returns the captured read data and the port width with a one-clock done pulse, then goes idle.

Top module: `abus_master_seq`

## Requirements
- R1: After reset, `as_n`, `ds_n` and `dben_n` are high, `d_oe` is low, `done` is low and `req_ready` is high.
- R2: On a read, `as_n` and `ds_n` both fall on the falling clock edge half a clock after the request is accepted. `dben_n` falls on the next rising edge.
- R3: On a write, `as_n` and `dben_n` fall together on the falling edge half a clock after acceptance. `d_oe` rises on the next rising edge and drives all 32 bits of the write data whatever the size. `ds_n` falls one full clock after `as_n`.
- R4: The acknowledge code `ack_n` = {bit1,bit0} ends the cycle and sets `done_port`. Code 2'b10 reports an 8-bit port (`done_port`=0), 2'b01 a 16-bit port (1) and 2'b00 a 32-bit port (2).
- R5: While `ack_n` is 2'b11 the cycle stretches. Each clock the slave delays its code adds exactly one clock to the width of `as_n`, and no `done` occurs meanwhile.
- R6: On a read, `d_in` is captured on the falling edge where the strobes negate, and returned on `done_rdata` while `done` is high.
- R7: `as_n`, `ds_n` and `dben_n` negate on the same falling edge. On the next rising edge `d_oe` drops and `done` pulses high for exactly one clock, with `req_ready` high in that clock.
- R8: `bus_addr`, `bus_size` and `bus_rw` (1 = read) equal the request while `as_n` is low and do not change during the cycle. `bus_size` codes the byte count as 2'b01=1, 2'b10=2, 2'b11=3, 2'b00=4.
- R9: An acknowledge code given while the sequencer is idle is ignored: no strobe asserts and no `done` occurs.
- R10: During a read cycle `d_oe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle; a request is taken on this rising edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Transfer address |
| req_size | input | 2 | Operand byte count (00=4, 01=1, 10=2, 11=3) |
| req_wdata | input | 32 | Write data |
| done | output | 1 | One-clock completion pulse |
| done_port | output | 2 | Reported port width (0=8, 1=16, 2=32 bit) |
| done_rdata | output | 32 | Captured read data |
| bus_addr | output | 32 | Address bus |
| bus_size | output | 2 | Operand size on the bus |
| bus_rw | output | 1 | 1 = read, 0 = write |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| dben_n | output | 1 | Data buffer enable, active low |
| d_out | output | 32 | Write data to the bus |
| d_oe | output | 1 | Data driver enable |
| d_in | input | 32 | Read data from the bus |
| ack_n | input | 2 | Termination and port-size acknowledge, active low |

## Verification
Two functions share one instant: termination and read-data capture both act on the falling edge where the strobes negate. The slave's model changes `d_in` only on rising edges and replaces the data with a decoy on the rising edge after the strobes drop. A correct capture returns the slave's value, and a capture one phase late returns the decoy. On every run, the edges of `as_n`, `ds_n`, `dben_n` and `d_oe` are timestamped in half-clock steps, so a strobe negating one phase off from the others is also caught.

// File: rtl/abus_pkg.sv
package abus_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACT  = 2'd1,
      ST_TERM = 2'd2
   } seq_state_e;

   typedef enum logic [1:0] {
      PORT_8  = 2'd0,
      PORT_16 = 2'd1,
      PORT_32 = 2'd2
   } port_w_e;

   // active-low acknowledge code to port width; 11 means no termination
   function automatic logic ack_valid(input logic [1:0] code);
      return code != 2'b11;
   endfunction

   function automatic port_w_e ack_port(input logic [1:0] code);
      case (code)
         2'b10:   return PORT_8;
         2'b01:   return PORT_16;
         default: return PORT_32;
      endcase
   endfunction
endpackage

// File: rtl/abus_ack_sync.sv
module abus_ack_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[0] <= '1;
      else        stage_q[0] <= din;
   end

   for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[g] <= '1;
         else        stage_q[g] <= stage_q[g-1];
      end
   end

   assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/abus_seq_ctrl.sv
module abus_seq_ctrl
   import abus_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [1:0]        ack_sync,
   input  logic [DATA_W-1:0] cap_data,
   output seq_state_e        state,
   output logic [CNT_W-1:0]  cnt,
   output logic              wr,
   output logic              rd_dben,
   output logic              oe,
   output logic [ADDR_W-1:0] addr,
   output logic [1:0]        size,
   output logic [DATA_W-1:0] wdata,
   output logic              done,
   output port_w_e           port,
   output logic [DATA_W-1:0] rdata
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] RD_MIN  = CNT_W'(1);
   localparam logic [CNT_W-1:0] WR_MIN  = CNT_W'(2);

   logic ack_ok;
   assign ack_ok = ack_valid(ack_sync) && (cnt >= (wr ? WR_MIN : RD_MIN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         wr      <= 1'b0;
         rd_dben <= 1'b0;
         oe      <= 1'b0;
         addr    <= '0;
         size    <= '0;
         wdata   <= '0;
         done    <= 1'b0;
         port    <= PORT_32;
         rdata   <= '0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: if (req_valid) begin
               state   <= ST_ACT;
               cnt     <= '0;
               wr      <= req_write;
               addr    <= req_addr;
               size    <= req_size;
               wdata   <= req_wdata;
            end
            ST_ACT: begin
               if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
               if (cnt == '0) begin
                  rd_dben <= !wr;
                  oe      <= wr;
               end
               if (ack_ok) begin
                  state <= ST_TERM;
                  port  <= ack_port(ack_sync);
               end
            end
            ST_TERM: begin
               state   <= ST_IDLE;
               done    <= 1'b1;
               oe      <= 1'b0;
               rd_dben <= 1'b0;
               rdata   <= cap_data;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/abus_strobe_phase.sv
module abus_strobe_phase
   import abus_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  seq_state_e        state,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              wr,
   input  logic [DATA_W-1:0] d_in,
   output logic              as_on,
   output logic              ds_on,
   output logic [DATA_W-1:0] cap_data
);
   // falling-edge registers: strobes open and close half a clock off the state
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         as_on    <= 1'b0;
         ds_on    <= 1'b0;
         cap_data <= '0;
      end else begin
         as_on <= (state == ST_ACT);
         ds_on <= (state == ST_ACT) && (!wr || cnt != '0);
         if (state == ST_TERM) cap_data <= d_in;
      end
   end
endmodule

// File: rtl/abus_master_seq.sv
module abus_master_seq
   import abus_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              done,
   output logic [1:0]        done_port,
   output logic [DATA_W-1:0] done_rdata,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [1:0]        bus_size,
   output logic              bus_rw,
   output logic              as_n,
   output logic              ds_n,
   output logic              dben_n,
   output logic [DATA_W-1:0] d_out,
   output logic              d_oe,
   input  logic [DATA_W-1:0] d_in,
   input  logic [1:0]        ack_n
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DATA_W % 8 != 0 || DATA_W > 32) begin : g_bad_data
      $error("DATA_W must be a byte multiple up to 32");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end

   seq_state_e        state;
   logic [CNT_W-1:0]  cnt;
   logic              wr, rd_dben, oe, as_on, ds_on;
   logic [1:0]        ack_s;
   logic [DATA_W-1:0] cap_data, wdata;
   port_w_e           port;

   abus_ack_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(ack_n), .dout(ack_s)
   );

   abus_seq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
      .ack_sync(ack_s), .cap_data(cap_data), .state(state), .cnt(cnt),
      .wr(wr), .rd_dben(rd_dben), .oe(oe), .addr(bus_addr), .size(bus_size),
      .wdata(wdata), .done(done), .port(port), .rdata(done_rdata)
   );

   abus_strobe_phase #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .state(state), .cnt(cnt), .wr(wr),
      .d_in(d_in), .as_on(as_on), .ds_on(ds_on), .cap_data(cap_data)
   );

   assign req_ready = (state == ST_IDLE);
   assign bus_rw    = !wr;
   assign as_n      = !as_on;
   assign ds_n      = !ds_on;
   assign dben_n    = !(as_on && (wr || rd_dben));
   assign d_oe      = oe;
   assign d_out     = wdata;
   assign done_port = port;
endmodule

// File: rtl/abus_master_seq_chk.sv
module abus_master_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_ready,
   input logic       done,
   input logic [31:0] bus_addr,
   input logic [1:0] bus_size,
   input logic       bus_rw,
   input logic       as_n,
   input logic       ds_n,
   input logic       dben_n,
   input logic       d_oe
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (as_n && ds_n && dben_n && !d_oe)); // R9
   AST_READ_DS_WITH_AS: assert property (@(posedge clk) disable iff (!rst_n)
      (!as_n && bus_rw) |-> !ds_n); // R2
   AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rw |-> !d_oe); // R10
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
   AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (req_ready && as_n)); // R7
   AST_WR_DBEN_WITH_AS: assert property (@(posedge clk) disable iff (!rst_n)
      (!as_n && !bus_rw) |-> !dben_n); // R3
   AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!as_n && $past(!as_n)) |-> ($stable(bus_addr) && $stable(bus_size) && $stable(bus_rw))); // R8
endmodule

bind abus_master_seq abus_master_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
   .bus_addr(bus_addr), .bus_size(bus_size), .bus_rw(bus_rw),
   .as_n(as_n), .ds_n(ds_n), .dben_n(dben_n), .d_oe(d_oe)
);

// File: tb/sim_abus_master_seq.sv
`timescale 1ns/1ps
module sim_abus_master_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [31:0] req_addr = '0, req_wdata = '0;
   logic [1:0]  req_size = '0;
   logic        req_ready, done, bus_rw, as_n, ds_n, dben_n, d_oe;
   logic [1:0]  done_port, bus_size;
   logic [31:0] done_rdata, bus_addr, d_out;
   logic [31:0] d_in = '0;
   logic [1:0]  ack_n = 2'b11;

   int checks = 0, fails = 0;

   always #10 clk = ~clk;

   abus_master_seq u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
      .req_wdata(req_wdata), .done(done), .done_port(done_port),
      .done_rdata(done_rdata), .bus_addr(bus_addr), .bus_size(bus_size),
      .bus_rw(bus_rw), .as_n(as_n), .ds_n(ds_n), .dben_n(dben_n),
      .d_out(d_out), .d_oe(d_oe), .d_in(d_in), .ack_n(ack_n)
   );

   // slave model: reacts on rising edges only
   logic [1:0]  slv_code = 2'b00;
   int          slv_wait = 0;
   logic [31:0] slv_data = '0;
   logic        slv_force = 1'b0;
   int          slv_cnt = 0;
   localparam logic [31:0] DECOY = 32'h0BAD_F00D;

   always @(posedge clk) begin
      if (slv_force) begin
         ack_n <= slv_code;
      end else if (!ds_n) begin
         d_in <= slv_data;
         if (slv_cnt >= slv_wait) ack_n <= slv_code;
         else begin
            ack_n   <= 2'b11;
            slv_cnt = slv_cnt + 1;
         end
      end else begin
         ack_n   <= 2'b11;
         d_in    <= DECOY;
         slv_cnt = 0;
      end
   end

   // half-phase monitor: samples a quarter clock after every edge
   int h = 0;
   int as_r, as_f, ds_r, ds_f, db_r, db_f, oe_r, oe_f, dn_h, dn_cnt;
   logic [1:0]  got_port;
   logic [31:0] got_rdata, got_dout;
   logic        got_ready, bus_bad;
   logic [31:0] exp_addr;
   logic [1:0]  exp_size;
   logic        exp_rw;

   task automatic mon_clear();
      as_r = -1; as_f = -1; ds_r = -1; ds_f = -1; db_r = -1; db_f = -1;
      oe_r = -1; oe_f = -1; dn_h = -1; dn_cnt = 0; bus_bad = 1'b0;
      got_dout = '0; got_ready = 1'b0;
   endtask

   always @(clk) begin
      #5;
      h = h + 1;
      if (!as_n && as_r < 0) as_r = h;
      if (as_n && as_r >= 0 && as_f < 0) as_f = h;
      if (!ds_n && ds_r < 0) ds_r = h;
      if (ds_n && ds_r >= 0 && ds_f < 0) ds_f = h;
      if (!dben_n && db_r < 0) db_r = h;
      if (dben_n && db_r >= 0 && db_f < 0) db_f = h;
      if (d_oe && oe_r < 0) begin oe_r = h; got_dout = d_out; end
      if (!d_oe && oe_r >= 0 && oe_f < 0) oe_f = h;
      if (!as_n && (bus_addr !== exp_addr || bus_size !== exp_size || bus_rw !== exp_rw))
         bus_bad = 1'b1;
      if (done) begin
         if (dn_h < 0) begin
            dn_h = h; got_port = done_port; got_rdata = done_rdata; got_ready = req_ready;
         end
         dn_cnt = dn_cnt + 1;
      end
   end

   task automatic check(input string req, input logic ok, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // issue one cycle and wait for it to complete
   task automatic run_cycle(input logic wr, input logic [31:0] a, input logic [1:0] sz,
                            input logic [31:0] wd, input logic [1:0] code, input int waits,
                            input logic [31:0] rd);
      mon_clear();
      slv_code = code; slv_wait = waits; slv_data = rd;
      exp_addr = a; exp_size = sz; exp_rw = !wr;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      for (int i = 0; i < 100 && dn_h < 0; i++) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1", as_n && ds_n && dben_n, {as_n, ds_n, dben_n}, 3'b111);
      check("R1", !d_oe && !done && req_ready, {d_oe, done, req_ready}, 3'b001);
   endtask

   task automatic t_read(input logic [1:0] code, input int exp_port, input logic [31:0] val);
      run_cycle(1'b0, 32'h1000_0040, 2'b00, '0, code, 0, val);
      check("R2 ds with as", ds_r == as_r, ds_r, as_r);
      check("R2 dben one phase later", db_r == as_r + 1, db_r, as_r + 1);
      check("R10 no drive on read", oe_r < 0, oe_r, -1);
      check("R4 port code", dn_h >= 0 && got_port == 2'(exp_port), got_port, exp_port);
      check("R6 read data", got_rdata == val, got_rdata, val);
      check("R7 strobes negate together", ds_f == as_f && db_f == as_f, {ds_f, db_f}, {as_f, as_f});
      check("R7 done next rising edge", dn_h == as_f + 1, dn_h, as_f + 1);
      check("R7 single done, ready", dn_cnt == 2 && got_ready, dn_cnt, 2);
      check("R8 bus fields stable", !bus_bad, bus_bad, 0);
   endtask

   task automatic t_write(input logic [1:0] sz, input logic [1:0] code, input int exp_port);
      run_cycle(1'b1, 32'h2000_0003, sz, 32'hA5C3_5A3C, code, 0, '0);
      check("R3 dben with as", db_r == as_r, db_r, as_r);
      check("R3 drivers on next rising", oe_r == as_r + 1, oe_r, as_r + 1);
      check("R3 all 32 bits driven", got_dout == 32'hA5C3_5A3C, got_dout, 32'hA5C3_5A3C);
      check("R3 ds one clock later", ds_r == as_r + 2, ds_r, as_r + 2);
      check("R4 port code", dn_h >= 0 && got_port == 2'(exp_port), got_port, exp_port);
      check("R7 dben/ds negate with as", db_f == as_f && ds_f == as_f, {db_f, ds_f}, {as_f, as_f});
      check("R7 drivers off with done", oe_f == as_f + 1 && dn_h == as_f + 1, oe_f, as_f + 1);
      check("R8 bus fields stable", !bus_bad, bus_bad, 0);
   endtask

   task automatic t_waits();
      int w0, w3;
      run_cycle(1'b0, 32'h3000_0000, 2'b10, '0, 2'b01, 0, 32'h1111_2222);
      w0 = as_f - as_r;
      run_cycle(1'b0, 32'h3000_0000, 2'b10, '0, 2'b01, 3, 32'h3333_4444);
      w3 = as_f - as_r;
      check("R5 three waits add three clocks", w3 == w0 + 6, w3, w0 + 6);
      check("R5 single done after waits", dn_cnt == 2, dn_cnt, 2);
      check("R6 read data after waits", got_rdata == 32'h3333_4444, got_rdata, 32'h3333_4444);
   endtask

   task automatic t_idle_ack();
      mon_clear();
      slv_force = 1'b1; slv_code = 2'b00;
      repeat (6) @(negedge clk);
      check("R9 no strobe from idle ack", as_r < 0 && ds_r < 0 && db_r < 0, as_r, -1);
      check("R9 no done from idle ack", dn_h < 0, dn_h, -1);
      slv_force = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      mon_clear();
      exp_addr = '0; exp_size = '0; exp_rw = 1'b1;
      #1 t_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_read(2'b00, 2, 32'hCAFE_1234);
      t_read(2'b10, 0, 32'h0000_00A7);
      t_read(2'b01, 1, 32'h55AA_0F0F);
      t_write(2'b01, 2'b10, 0);
      t_write(2'b11, 2'b00, 2);
      t_write(2'b00, 2'b01, 1);
      t_waits();
      t_idle_ack();
      t_read(2'b00, 2, 32'h0123_4567);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #3000000;
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule